// File: doc/BRIEF.md
# End-of-Chain Request Error Responder

This block terminates requests at the last device of a chain of packet links. A reordering stage offers it one request at a time: a command class, a has-data bit, a tag, a data-buffer address and a flag for a failed 64-bit address extension. When an end-of-chain error condition applies, the block takes the request and returns a one-cycle acknowledge. Without that condition, it leaves the request alone.

What happens next depends on the command class:
- A posted request that carries data has its buffered payload discarded through a drop strobe to the data buffer.
- A non-posted write is answered with a target-done response toward flow control.
- A non-posted read is answered with a read response followed by a data phase, and each of the two phases waits for its own consume handshake.
- Broadcast, flush and atomic commands are acknowledged and then ignored.

Only one sequence runs at a time. While a sequence runs, new requests are refused.

Top module: `eoc_responder`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle. After that edge, `req_ack`, `fc_valid` and `buf_drop` are 0 and `buf_addr` is 0.
- R2: While `req_valid` is 0, `req_ack` is 0 and no flow-control or drop activity starts, whatever the other request inputs carry.
- R3: While `req_valid` is 1 and `eoc_err` is 0, `req_ack` is 0, the request is not taken, and no activity follows.
- R4: When the block is idle with `req_valid` and `eoc_err` both 1, `req_ack` is 1 in that same cycle, and the request's address, tag, class and extension-error flag are latched at the next rising edge. The `req_class` codes are: 0 broadcast, 1 posted write, 2 non-posted write, 3 non-posted read, 4 posted read, 5 flush, 6 atomic, 7 unused.
- R5: Some accepted requests produce no `fc_valid` and no `buf_drop`, and the block is ready for the next request in the following cycle. These are classes 0, 5, 6 and 7, and classes 1 and 4 with `req_has_data` 0.
- R6: An accepted posted request (class 1 or 4) with `req_has_data` 1 has its data discarded in two steps.
  - In the cycle after acceptance, `buf_addr` shows the latched address, `buf_vc` is 2'b00 and `buf_drop` is 0.
  - In the next cycle, `buf_drop` is 1 for exactly one cycle.
  - No response is sent.
- R7: For an accepted non-posted write, `fc_valid` rises in the cycle after acceptance and holds until `fc_consume` is 1 at a rising edge, then falls.
  - `fc_word` carries the tag in bits [W-1:7], the extension-error flag in bit 6 and the target-done code 6'h33 in bits [5:0].
- R8: For an accepted non-posted read, `fc_valid` follows the sequence 1, 0, 1, 0.
  - First phase: the read-response word, same layout as R7 with code 6'h30, until consume is seen high.
  - Gap: `fc_valid` is 0 until consume is seen low.
  - Data phase: `fc_word` equals `buf_rdata`, with `buf_addr` at the latched address, until consume is seen high.
- R9: While any drop or response sequence is in progress, `req_ack` stays 0 even with `req_valid` and `eoc_err` high.
- R10: Bit 6 of a response word reproduces the `req_ext_err` value that was latched with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_class | input | 3 | Command class code |
| req_has_data | input | 1 | Request carries buffered data |
| req_tag | input | TAG_W | Tag copied into response words |
| req_ext_err | input | 1 | 64-bit address-extension error flag |
| req_addr | input | AW | Data-buffer address of the request |
| eoc_err | input | 1 | End-of-chain error condition applies |
| req_ack | output | 1 | Request taken this cycle |
| fc_word | output | TAG_W+7 | Response or data word |
| fc_valid | output | 1 | `fc_word` is offered |
| fc_consume | input | 1 | Flow control consumes the offered word |
| buf_rdata | input | TAG_W+7 | Data word read from the buffer |
| buf_addr | output | AW | Latched data-buffer address |
| buf_vc | output | 2 | Channel type: 00 posted, 01 non-posted |
| buf_drop | output | 1 | Discard the data at `buf_addr` |

## Verification
The acknowledge is combinational, so the bench checks it in the same cycle the request is driven, one nanosecond after the falling edge. Every other result is due a fixed number of rising edges after acceptance:
- The drop address, the target-done word and the read-response word are due one edge after acceptance.
- The drop pulse is due two edges after acceptance.
- The data phase is due one edge after consume is seen low.

The bench drives all inputs at falling edges and samples at the following falling edge. Each expectation therefore lands exactly on the cycle it predicts. The bench sweeps every class, has-data value and error-condition value.

// File: rtl/eoc_responder.sv
module eoc_responder #(
  parameter int TAG_W = 25,
  parameter int AW    = 4,
  localparam int W    = TAG_W + 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_class,
  input  logic             req_has_data,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_ext_err,
  input  logic [AW-1:0]    req_addr,
  input  logic             eoc_err,
  output logic             req_ack,
  output logic [W-1:0]     fc_word,
  output logic             fc_valid,
  input  logic             fc_consume,
  input  logic [W-1:0]     buf_rdata,
  output logic [AW-1:0]    buf_addr,
  output logic [1:0]       buf_vc,
  output logic             buf_drop
);

  localparam logic [2:0] C_BCAST = 3'd0;
  localparam logic [2:0] C_PWR   = 3'd1;
  localparam logic [2:0] C_NPWR  = 3'd2;
  localparam logic [2:0] C_NPRD  = 3'd3;
  localparam logic [2:0] C_PRD   = 3'd4;
  localparam logic [2:0] C_FLUSH = 3'd5;
  localparam logic [2:0] C_ATOM  = 3'd6;

  localparam logic [5:0] CODE_DONE = 6'h33;
  localparam logic [5:0] CODE_RRSP = 6'h30;

  typedef enum logic [2:0] {
    S_IDLE, S_DADDR, S_DPULSE, S_DONE, S_RRSP, S_RGAP, S_RDATA
  } st_t;

  st_t              st, st_n;
  logic [2:0]       cls_q;
  logic [TAG_W-1:0] tag_q;
  logic             err_q;
  logic [AW-1:0]    addr_q;

  assign req_ack = (st == S_IDLE) && req_valid && eoc_err;

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:
        if (req_ack) begin
          case (req_class)
            C_PWR, C_PRD: st_n = req_has_data ? S_DADDR : S_IDLE;
            C_NPWR:       st_n = S_DONE;
            C_NPRD:       st_n = S_RRSP;
            default:      st_n = S_IDLE;
          endcase
        end
      S_DADDR:  st_n = S_DPULSE;
      S_DPULSE: st_n = S_IDLE;
      S_DONE:   st_n = fc_consume ? S_IDLE : S_DONE;
      S_RRSP:   st_n = fc_consume ? S_RGAP : S_RRSP;
      S_RGAP:   st_n = fc_consume ? S_RGAP : S_RDATA;
      S_RDATA:  st_n = fc_consume ? S_IDLE : S_RDATA;
      default:  st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cls_q  <= C_BCAST;
      tag_q  <= '0;
      err_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      st <= st_n;
      if (req_ack) begin
        cls_q  <= req_class;
        tag_q  <= req_tag;
        err_q  <= req_ext_err;
        addr_q <= req_addr;
      end
    end
  end

  assign fc_valid = (st == S_DONE) || (st == S_RRSP) || (st == S_RDATA);
  assign fc_word  = (st == S_RDATA) ? buf_rdata
                  : {tag_q, err_q, (st == S_DONE) ? CODE_DONE : CODE_RRSP};
  assign buf_drop = (st == S_DPULSE);
  assign buf_addr = addr_q;
  assign buf_vc   = (cls_q == C_NPWR || cls_q == C_NPRD ||
                     cls_q == C_FLUSH || cls_q == C_ATOM) ? 2'b01 : 2'b00;

endmodule

module eoc_responder_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          eoc_err,
  input logic          req_ack,
  input logic          fc_valid,
  input logic          fc_consume,
  input logic          buf_drop,
  input logic [AW-1:0] buf_addr
);

  assert_ack_needs_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (req_valid && eoc_err));

  assert_busy_no_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_valid || buf_drop) |-> !req_ack);

  assert_drop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_drop |=> !buf_drop);

  assert_drop_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_drop) |-> $stable(buf_addr));

  assert_fc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_valid && !fc_consume) |=> fc_valid);

  assert_fc_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_valid && fc_consume) |=> !fc_valid);

endmodule

bind eoc_responder eoc_responder_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_eoc_responder.sv
module tb_eoc_responder;
  localparam int TAG_W = 25;
  localparam int AW    = 4;
  localparam int W     = TAG_W + 7;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid, req_has_data, req_ext_err, eoc_err, fc_consume;
  logic [2:0]       req_class;
  logic [TAG_W-1:0] req_tag;
  logic [AW-1:0]    req_addr;
  logic [W-1:0]     buf_rdata;
  logic             req_ack, fc_valid, buf_drop;
  logic [W-1:0]     fc_word;
  logic [AW-1:0]    buf_addr;
  logic [1:0]       buf_vc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  eoc_responder #(.TAG_W(TAG_W), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_has_data(req_has_data), .req_tag(req_tag), .req_ext_err(req_ext_err),
    .req_addr(req_addr), .eoc_err(eoc_err), .req_ack(req_ack),
    .fc_word(fc_word), .fc_valid(fc_valid), .fc_consume(fc_consume),
    .buf_rdata(buf_rdata), .buf_addr(buf_addr), .buf_vc(buf_vc),
    .buf_drop(buf_drop));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_cmd(input int cls, input bit hd, input bit eoc,
                         input logic [AW-1:0] addr, input logic [TAG_W-1:0] tag,
                         input bit ext, input logic [W-1:0] rdat);
    bit posted_drop;
    posted_drop = (cls == 1 || cls == 4) && hd;
    req_valid = 1; req_class = cls[2:0]; req_has_data = hd; eoc_err = eoc;
    req_addr = addr; req_tag = tag; req_ext_err = ext; buf_rdata = rdat;
    #1 chk(eoc ? "R4 ack" : "R3 no ack", W'(req_ack), W'(eoc));
    step();
    req_valid = 0; eoc_err = 0;
    #1;
    if (!eoc) begin
      chk("R3 no fc", W'(fc_valid), 0);
      chk("R3 no drop", W'(buf_drop), 0);
      return;
    end
    if (posted_drop) begin
      chk("R6 addr phase drop low", W'(buf_drop), 0);
      chk("R6 addr", W'(buf_addr), W'(addr));
      chk("R6 vc", W'(buf_vc), 0);
      chk("R6 no fc", W'(fc_valid), 0);
      req_valid = 1; eoc_err = 1;
      #1 chk("R9 busy drop", W'(req_ack), 0);
      step();
      chk("R6 drop pulse", W'(buf_drop), 1);
      chk("R6 addr at drop", W'(buf_addr), W'(addr));
      chk("R9 busy pulse", W'(req_ack), 0);
      req_valid = 0; eoc_err = 0;
      step();
      chk("R6 drop one cycle", W'(buf_drop), 0);
    end else if (cls == 2) begin
      chk("R7 valid", W'(fc_valid), 1);
      chk("R7 R10 word", fc_word, {tag, ext, 6'h33});
      req_valid = 1; eoc_err = 1;
      #1 chk("R9 busy write", W'(req_ack), 0);
      step();
      chk("R7 hold", W'(fc_valid), 1);
      req_valid = 0; eoc_err = 0; fc_consume = 1;
      step();
      fc_consume = 0;
      chk("R7 release", W'(fc_valid), 0);
    end else if (cls == 3) begin
      chk("R8 rsp valid", W'(fc_valid), 1);
      chk("R8 R10 rsp word", fc_word, {tag, ext, 6'h30});
      req_valid = 1; eoc_err = 1;
      #1 chk("R9 busy read", W'(req_ack), 0);
      req_valid = 0; eoc_err = 0;
      fc_consume = 1;
      step();
      chk("R8 gap", W'(fc_valid), 0);
      step();
      chk("R8 gap while consume high", W'(fc_valid), 0);
      fc_consume = 0;
      step();
      chk("R8 data valid", W'(fc_valid), 1);
      chk("R8 data word", fc_word, rdat);
      chk("R8 data addr", W'(buf_addr), W'(addr));
      fc_consume = 1;
      step();
      fc_consume = 0;
      chk("R8 end", W'(fc_valid), 0);
    end else begin
      chk("R5 no fc", W'(fc_valid), 0);
      chk("R5 no drop", W'(buf_drop), 0);
      req_valid = 1; eoc_err = 1;
      #1 chk("R5 ready again", W'(req_ack), 1);
      req_valid = 0; eoc_err = 0;
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_class = 0; req_has_data = 0; req_ext_err = 0;
    req_addr = 0; req_tag = 0; eoc_err = 0; fc_consume = 0; buf_rdata = 0;
    @(negedge clk);
    step();
    chk("R1 ack", W'(req_ack), 0);
    chk("R1 fc", W'(fc_valid), 0);
    chk("R1 drop", W'(buf_drop), 0);
    chk("R1 addr", W'(buf_addr), 0);
    rst_n = 1;
    step();

    for (int c = 0; c < 8; c++) begin
      req_valid = 0; req_class = c[2:0]; req_has_data = 1; eoc_err = 1;
      req_ext_err = 1; req_addr = 4'hF;
      #1 chk("R2 ack low", W'(req_ack), 0);
      step();
      chk("R2 no fc", W'(fc_valid), 0);
      chk("R2 no drop", W'(buf_drop), 0);
    end
    eoc_err = 0;

    for (int c = 0; c < 8; c++)
      for (int h = 0; h < 2; h++)
        for (int e = 0; e < 2; e++) begin
          int k;
          k = c * 4 + h * 2 + e;
          run_cmd(c, h[0], e[0], AW'(k * 3 + 1), TAG_W'(25'h1A5F00 + k * 37),
                  (c[0] ^ h[0]), W'(32'hC0DE0000 + k * 257));
          step();
        end

    run_cmd(1, 1'b1, 1'b1, 4'h0, 25'h0, 1'b0, '0);
    step();

    rst_n = 0;
    run_cmd(3, 1'b0, 1'b0, 4'h5, 25'h1, 1'b0, '0);
    step();
    chk("R1 reset again fc", W'(fc_valid), 0);
    chk("R1 reset again addr", W'(buf_addr), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule